// File: doc/BRIEF.md
# Banked DMA Channel Register File

This block is the software-facing register file of a multi-channel DMA engine. A host reaches it over a simple register bus that takes one access per cycle. The bus has an address, write data, a write strobe and a read strobe, and read data is returned on the cycle after the read strobe. Each channel's settings are not mapped one after another. Software first writes a channel number into a select register, and that channel's bank then appears at a fixed group of offsets. Port settings are reached the same way, through their own select register.

The block drives each channel's enable, direction, weight, descriptor ring base and descriptor count to the datapath. Each channel has event inputs that set status bits. A channel raises its interrupt line when an enabled status bit is pending and that channel's line is unmasked in a global mask register. A channel reset clears itself a fixed number of cycles after it is requested, so software can poll for it. An engine reset starts the same sequence on every channel at once.

Top module: `dma_chan_regs`

## Requirements
- R1: A read of offset 0x08 returns the hardware revision in bits 4:0, the port count in bits 19:16 and the channel count in bits 31:20, with all other bits 0 (defaults: revision 0x12, 4 ports, 20 channels, giving 0x01440012).
- R2: Offset 0x18 holds the channel select and reads back the value written. The selected channel's bank appears at 0x14 (poll), 0x1C (control), 0x20 (descriptor base), 0x24 (descriptor count), 0x28 (status) and 0x2C (interrupt enable). Read data appears on the cycle after the read strobe. An unmapped offset reads 0.
- R3: In the control register, bit 0 is the channel enable, bit 8 is transmit direction and bits 17:16 are the weight. A write drives these values on the selected channel's outputs and leaves every other channel unchanged.
- R4: Writing 1 to control bit 1 starts a channel reset. The bit reads 1 on reads sampled in the 4 cycles after the write and reads 0 from the 5th cycle on. During the reset the channel's enable and status clear and its events are ignored. The descriptor base and count are kept.
- R5: Writing 1 to bit 0 of offset 0x10 starts a channel reset on every channel. That bit reads 1 while any channel is still resetting, and every channel enable is 0 on the next cycle.
- R6: Event input bit b of a channel (7 bits per channel) sets status bit b. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Writing 0x7E therefore clears bits 6:1 and keeps bit 0.
- R7: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R8: Offset 0xF4 holds one line-enable bit per channel, with bit n belonging to channel n. Interrupt output n is high exactly when (status AND interrupt enable) of channel n is non-zero and line-enable bit n is 1.
- R9: The poll register of the selected channel stores bit 31 (poll enable) and bit 6 (divide-by-4 poll clock). All its other bits read 0, and each channel keeps its own copy.
- R10: Offset 0x40 holds the port select, and offset 0x44 shows the selected port's configuration. That register stores bits 11:8 (swap enables), bit 6 (drop on arbitration loss) and the two burst fields at bits 5:4 and 3:2, and all other bits read 0. A port select of 4 or more reads 0 and ignores writes.
- R11: While the channel select is 20 or more, every banked register reads 0 and writes to banked registers change no channel.
- R12: After reset, all channel, port, select and mask registers are 0, and every interrupt and channel enable output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered, valid the cycle after rd_en |
| ch_event_i | input | NUM_CH*STAT_W | Per-channel status-set events, channel n at [STAT_W*n +: STAT_W] |
| irq_o | output | NUM_CH | Per-channel interrupt lines |
| ch_on_o | output | NUM_CH | Per-channel enable |
| ch_tx_o | output | NUM_CH | Per-channel transmit direction |
| ch_weight_o | output | NUM_CH*2 | Per-channel weight, channel n at [2n +: 2] |
| ch_base_o | output | NUM_CH*DATA_W | Per-channel descriptor ring base |
| ch_count_o | output | NUM_CH*CNT_W | Per-channel descriptor count |

## Verification
Every one of the 20 channels is written with its own control, base and count pattern and then read back through the select register. This would expose a bank written at the wrong index or a select that aliases. Status bits are walked one at a time against a matching and a non-matching interrupt enable. This separates the per-bit AND from a plain OR of the status bits. Colliding event and clear writes, and events arriving while a channel is resetting, test the R7 priority and the R4 reset window. Out-of-range channel and port selects, and reads polled cycle by cycle after a reset request, fix the reset length at exactly 4 cycles and show that unused selects reach nothing.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  // register offsets (software-visible decode)
  localparam int OFS_ID    = 'h08;
  localparam int OFS_GCTRL = 'h10;
  localparam int OFS_POLL  = 'h14;
  localparam int OFS_CSEL  = 'h18;
  localparam int OFS_CCTRL = 'h1C;
  localparam int OFS_CBASE = 'h20;
  localparam int OFS_CCNT  = 'h24;
  localparam int OFS_CSTAT = 'h28;
  localparam int OFS_CIEN  = 'h2C;
  localparam int OFS_PSEL  = 'h40;
  localparam int OFS_PCFG  = 'h44;
  localparam int OFS_LINE  = 'hF4;

  // channel control fields
  localparam int CTL_ON    = 0;
  localparam int CTL_RST   = 1;
  localparam int CTL_TX    = 8;
  localparam int CTL_WT_LO = 16;

  // poll fields
  localparam int POLL_EN  = 31;
  localparam int POLL_DIV = 6;

  // port config fields
  localparam int PC_SWAP_LO = 8;
  localparam int PC_DROP    = 6;
  localparam int PC_BA_LO   = 4;
  localparam int PC_BB_LO   = 2;

  // global control fields
  localparam int GC_RST = 0;

  typedef enum logic [2:0] {
    BK_NONE, BK_CTRL, BK_BASE, BK_CNT, BK_STAT, BK_IEN, BK_POLL
  } bank_reg_e;
endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_regs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STAT_W  = 7,
  parameter int CNT_W   = 8,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  bank_reg_e         wr_reg,
  input  bank_reg_e         rd_reg,
  input  logic [DATA_W-1:0] wdata,
  input  logic              eng_rst,
  input  logic [STAT_W-1:0] ev,
  output logic              on_o,
  output logic              tx_o,
  output logic [1:0]        wt_o,
  output logic [DATA_W-1:0] base_o,
  output logic [CNT_W-1:0]  dcnt_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] ien_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rd_word
);
  localparam int RC_W = $clog2(RST_CYC + 1);

  logic              on_q, on_d, tx_q, tx_d;
  logic [1:0]        wt_q, wt_d;
  logic [DATA_W-1:0] base_q;
  logic [CNT_W-1:0]  dcnt_q;
  logic [STAT_W-1:0] stat_q, stat_d, ien_q, stat_clr;
  logic              pen_q, pdiv_q;
  logic [RC_W-1:0]   rc_q, rc_d;
  logic              rst_go, busy;
  logic              ctrl_we, base_we, dcnt_we, ien_we, poll_we;

  assign busy = (rc_q != '0);

  // next state
  always_comb begin
    ctrl_we  = wr_hit && (wr_reg == BK_CTRL);
    base_we  = wr_hit && (wr_reg == BK_BASE);
    dcnt_we  = wr_hit && (wr_reg == BK_CNT);
    ien_we   = wr_hit && (wr_reg == BK_IEN);
    poll_we  = wr_hit && (wr_reg == BK_POLL);
    stat_clr = (wr_hit && (wr_reg == BK_STAT)) ? wdata[STAT_W-1:0] : '0;
    rst_go   = eng_rst || (ctrl_we && wdata[CTL_RST]);

    if (rst_go)    rc_d = RC_W'(RST_CYC);
    else if (busy) rc_d = rc_q - RC_W'(1);
    else           rc_d = rc_q;

    on_d   = ctrl_we ? wdata[CTL_ON] : on_q;
    tx_d   = ctrl_we ? wdata[CTL_TX] : tx_q;
    wt_d   = ctrl_we ? wdata[CTL_WT_LO +: 2] : wt_q;
    // an event wins over a clear of the same bit
    stat_d = (stat_q & ~stat_clr) | ev;

    if (rst_go || busy) begin
      on_d   = 1'b0;
      stat_d = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      tx_q   <= 1'b0;
      wt_q   <= '0;
      stat_q <= '0;
      rc_q   <= '0;
    end else begin
      on_q   <= on_d;
      tx_q   <= tx_d;
      wt_q   <= wt_d;
      stat_q <= stat_d;
      rc_q   <= rc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      dcnt_q <= '0;
      ien_q  <= '0;
      pen_q  <= 1'b0;
      pdiv_q <= 1'b0;
    end else begin
      if (base_we) base_q <= wdata;
      if (dcnt_we) dcnt_q <= wdata[CNT_W-1:0];
      if (ien_we)  ien_q  <= wdata[STAT_W-1:0];
      if (poll_we) begin
        pen_q  <= wdata[POLL_EN];
        pdiv_q <= wdata[POLL_DIV];
      end
    end
  end

  // local read word
  always_comb begin
    rd_word = '0;
    case (rd_reg)
      BK_CTRL: begin
        rd_word[CTL_ON]          = on_q;
        rd_word[CTL_RST]         = busy;
        rd_word[CTL_TX]          = tx_q;
        rd_word[CTL_WT_LO +: 2]  = wt_q;
      end
      BK_BASE: rd_word = base_q;
      BK_CNT:  rd_word[CNT_W-1:0]  = dcnt_q;
      BK_STAT: rd_word[STAT_W-1:0] = stat_q;
      BK_IEN:  rd_word[STAT_W-1:0] = ien_q;
      BK_POLL: begin
        rd_word[POLL_EN]  = pen_q;
        rd_word[POLL_DIV] = pdiv_q;
      end
      default: rd_word = '0;
    endcase
  end

  assign on_o   = on_q;
  assign tx_o   = tx_q;
  assign wt_o   = wt_q;
  assign base_o = base_q;
  assign dcnt_o = dcnt_q;
  assign stat_o = stat_q;
  assign ien_o  = ien_q;
  assign busy_o = busy;
endmodule

// File: rtl/dma_port_slot.sv
module dma_port_slot
  import dma_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  logic [3:0] swap_q;
  logic       drop_q;
  logic [1:0] bla_q, blb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_q <= '0;
      drop_q <= 1'b0;
      bla_q  <= '0;
      blb_q  <= '0;
    end else if (we) begin
      swap_q <= wdata[PC_SWAP_LO +: 4];
      drop_q <= wdata[PC_DROP];
      bla_q  <= wdata[PC_BA_LO +: 2];
      blb_q  <= wdata[PC_BB_LO +: 2];
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[PC_SWAP_LO +: 4] = swap_q;
    rd_word[PC_DROP]         = drop_q;
    rd_word[PC_BA_LO +: 2]   = bla_q;
    rd_word[PC_BB_LO +: 2]   = blb_q;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int         NUM_CH   = 20,
  parameter int         NUM_PORT = 4,
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 32,
  parameter int         STAT_W   = 7,
  parameter int         CNT_W    = 8,
  parameter int         RST_CYC  = 4,
  parameter logic [4:0] HW_REV   = 5'h12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  input  logic [NUM_CH*STAT_W-1:0]   ch_event_i,
  output logic [NUM_CH-1:0]          irq_o,
  output logic [NUM_CH-1:0]          ch_on_o,
  output logic [NUM_CH-1:0]          ch_tx_o,
  output logic [NUM_CH*2-1:0]        ch_weight_o,
  output logic [NUM_CH*DATA_W-1:0]   ch_base_o,
  output logic [NUM_CH*CNT_W-1:0]    ch_count_o
);
  localparam int CSEL_W = $clog2(NUM_CH) + 1;
  localparam int PSEL_W = $clog2(NUM_PORT) + 1;

  logic [1:0]        rsync_q;
  logic              rst_int_n;
  logic [CSEL_W-1:0] csel_q, csel_d;
  logic [PSEL_W-1:0] psel_q, psel_d;
  logic [NUM_CH-1:0] line_q, line_d;
  logic [DATA_W-1:0] rd_d, rdata_q, id_word;
  logic              eng_rst;
  bank_reg_e         bank;

  logic [NUM_CH-1:0] busy;
  logic [STAT_W-1:0] stat_w [NUM_CH];
  logic [STAT_W-1:0] ien_w  [NUM_CH];
  logic [DATA_W-1:0] slot_word [NUM_CH];
  logic [DATA_W-1:0] port_word [NUM_PORT];

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  function automatic bank_reg_e bank_of(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_W'(OFS_CCTRL): return BK_CTRL;
      ADDR_W'(OFS_CBASE): return BK_BASE;
      ADDR_W'(OFS_CCNT):  return BK_CNT;
      ADDR_W'(OFS_CSTAT): return BK_STAT;
      ADDR_W'(OFS_CIEN):  return BK_IEN;
      ADDR_W'(OFS_POLL):  return BK_POLL;
      default:            return BK_NONE;
    endcase
  endfunction

  assign bank    = bank_of(addr);
  assign eng_rst = wr_en && (addr == ADDR_W'(OFS_GCTRL)) && wdata[GC_RST];

  always_comb begin
    id_word         = '0;
    id_word[4:0]    = HW_REV;
    id_word[19:16]  = 4'(NUM_PORT);
    id_word[31:20]  = 12'(NUM_CH);
  end

  // global next state
  always_comb begin
    csel_d = csel_q;
    psel_d = psel_q;
    line_d = line_q;
    if (wr_en) begin
      if (addr == ADDR_W'(OFS_CSEL)) csel_d = wdata[CSEL_W-1:0];
      if (addr == ADDR_W'(OFS_PSEL)) psel_d = wdata[PSEL_W-1:0];
      if (addr == ADDR_W'(OFS_LINE)) line_d = wdata[NUM_CH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      csel_q <= '0;
      psel_q <= '0;
      line_q <= '0;
    end else begin
      csel_q <= csel_d;
      psel_q <= psel_d;
      line_q <= line_d;
    end
  end

  // channel banks
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_hit;
    assign wr_hit = wr_en && (bank != BK_NONE) && (csel_q == CSEL_W'(c));

    dma_chan_slot #(
      .DATA_W (DATA_W),
      .STAT_W (STAT_W),
      .CNT_W  (CNT_W),
      .RST_CYC(RST_CYC)
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .wr_hit (wr_hit),
      .wr_reg (bank),
      .rd_reg (bank),
      .wdata  (wdata),
      .eng_rst(eng_rst),
      .ev     (ch_event_i[STAT_W*c +: STAT_W]),
      .on_o   (ch_on_o[c]),
      .tx_o   (ch_tx_o[c]),
      .wt_o   (ch_weight_o[2*c +: 2]),
      .base_o (ch_base_o[DATA_W*c +: DATA_W]),
      .dcnt_o (ch_count_o[CNT_W*c +: CNT_W]),
      .stat_o (stat_w[c]),
      .ien_o  (ien_w[c]),
      .busy_o (busy[c]),
      .rd_word(slot_word[c])
    );

    assign irq_o[c] = line_q[c] && ((stat_w[c] & ien_w[c]) != '0);
  end

  // port banks
  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
    logic we;
    assign we = wr_en && (addr == ADDR_W'(OFS_PCFG)) && (psel_q == PSEL_W'(p));

    dma_port_slot #(.DATA_W(DATA_W)) u_port (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .we     (we),
      .wdata  (wdata),
      .rd_word(port_word[p])
    );
  end

  // read mux; out-of-range selects match no bank and read zero
  always_comb begin
    rd_d = '0;
    case (addr)
      ADDR_W'(OFS_ID):    rd_d = id_word;
      ADDR_W'(OFS_GCTRL): rd_d[GC_RST] = (busy != '0);
      ADDR_W'(OFS_CSEL):  rd_d[CSEL_W-1:0] = csel_q;
      ADDR_W'(OFS_PSEL):  rd_d[PSEL_W-1:0] = psel_q;
      ADDR_W'(OFS_LINE):  rd_d[NUM_CH-1:0] = line_q;
      ADDR_W'(OFS_PCFG): begin
        for (int p = 0; p < NUM_PORT; p++)
          if (psel_q == PSEL_W'(p)) rd_d = port_word[p];
      end
      default: begin
        if (bank != BK_NONE)
          for (int c = 0; c < NUM_CH; c++)
            if (csel_q == CSEL_W'(c)) rd_d = slot_word[c];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 20,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int CSEL_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        addr,
  input logic [DATA_W-1:0]        wdata,
  input logic [CSEL_W-1:0]        csel,
  input logic [NUM_CH-1:0]        irq_o,
  input logic [NUM_CH-1:0]        ch_on_o,
  input logic [NUM_CH*DATA_W-1:0] ch_base_o,
  input logic [NUM_CH*CNT_W-1:0]  ch_count_o
);
  logic eng_wr;
  assign eng_wr = wr_en && (addr == ADDR_W'(OFS_GCTRL)) && wdata[GC_RST];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    AST_CHRST_DROPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_CCTRL) && wdata[CTL_RST] && csel == CSEL_W'(c))
      |=> !ch_on_o[c]); // R4
    AST_LINE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_LINE) && !wdata[c]) |=> !irq_o[c]); // R8
  end

  AST_ENGRST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr |=> (ch_on_o == '0)); // R5

  AST_ENGRST_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr |=> ($stable(ch_base_o) && $stable(ch_count_o))); // R4

  AST_BADSEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && csel >= CSEL_W'(NUM_CH)) |=> ($stable(ch_base_o) && $stable(ch_count_o))); // R11
endmodule

bind dma_chan_regs dma_chan_regs_chk #(
  .NUM_CH(NUM_CH),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CNT_W (CNT_W),
  .CSEL_W(CSEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .csel      (csel_q),
  .irq_o     (irq_o),
  .ch_on_o   (ch_on_o),
  .ch_base_o (ch_base_o),
  .ch_count_o(ch_count_o)
);

// File: tb/sim_dma_chan_regs.sv
`timescale 1ns/1ps
module sim_dma_chan_regs;
  localparam int NCH = 20;
  localparam int NP  = 4;
  localparam int SW  = 7;
  localparam int CW  = 8;
  localparam int DW  = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, wr_en, rd_en;
  logic [7:0]        addr;
  logic [DW-1:0]     wdata, rdata;
  logic [NCH*SW-1:0] ev;
  logic [NCH-1:0]    irq, on, tx;
  logic [NCH*2-1:0]  wt;
  logic [NCH*DW-1:0] base;
  logic [NCH*CW-1:0] cnt;

  dma_chan_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_event_i(ev), .irq_o(irq),
    .ch_on_o(on), .ch_tx_o(tx), .ch_weight_o(wt), .ch_base_o(base),
    .ch_count_o(cnt)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic pulse(input int ch, input logic [SW-1:0] bits);
    ev[SW*ch +: SW] = bits;
    @(negedge clk);
    ev = '0;
  endtask

  function automatic logic [31:0] ctl_exp(input int c);
    return 32'h1 | (32'(c & 1) << 8) | (32'(c % 4) << 16);
  endfunction

  function automatic logic [31:0] base_exp(input int c);
    return 32'h1000_0000 + 32'(c) * 32'h111;
  endfunction

  logic [NCH*DW-1:0] base_snap;
  logic [NCH-1:0]    on_snap;

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; ev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 on", 32'(on), 32'h0);
    check("R12 irq", 32'(irq), 32'h0);
    rdchk("R12 ctrl ch0", 8'h1C, 32'h0);
    rdchk("R12 line", 8'hF4, 32'h0);
    rdchk("R12 base ch0", 8'h20, 32'h0);
    // R1 identification
    rdchk("R1 id", 8'h08, (32'(NCH) << 20) | (32'(NP) << 16) | 32'h12);
    rdchk("R2 unmapped", 8'h30, 32'h0);

    // R2 R3 sweep of every channel
    for (int c = 0; c < NCH; c++) begin
      wr(8'h18, 32'(c));
      wr(8'h1C, ctl_exp(c));
      wr(8'h20, base_exp(c));
      wr(8'h24, 32'(c + 3));
    end
    for (int c = 0; c < NCH; c++) begin
      wr(8'h18, 32'(c));
      rdchk("R2 csel", 8'h18, 32'(c));
      rdchk("R3 ctrl", 8'h1C, ctl_exp(c));
      rdchk("R2 base", 8'h20, base_exp(c));
      rdchk("R2 count", 8'h24, 32'(c + 3));
      check("R3 on out", 32'(on[c]), 32'h1);
      check("R3 tx out", 32'(tx[c]), 32'(c & 1));
      check("R3 weight out", 32'(wt[2*c +: 2]), 32'(c % 4));
      check("R3 base out", base[DW*c +: DW], base_exp(c));
      check("R3 count out", 32'(cnt[CW*c +: CW]), 32'(c + 3));
    end

    // R11 out-of-range channel selects
    base_snap = base; on_snap = on;
    for (int s = NCH; s < 64; s += 11) begin
      wr(8'h18, 32'(s));
      wr(8'h20, 32'hDEAD_BEEF);
      wr(8'h24, 32'h55);
      wr(8'h1C, 32'h0);
      rdchk("R11 base reads 0", 8'h20, 32'h0);
      rdchk("R11 ctrl reads 0", 8'h1C, 32'h0);
      rdchk("R2 csel readback", 8'h18, 32'(s));
      check("R11 base unchanged", 32'(base == base_snap), 32'h1);
      check("R11 on unchanged", 32'(on), 32'(on_snap));
    end

    // R6 R8 status walk on channel 2
    wr(8'h18, 32'd2);
    wr(8'hF4, 32'h4);
    for (int b = 0; b < SW; b++) begin
      wr(8'h28, 32'h7F);
      wr(8'h2C, 32'h1 << b);
      pulse(2, 7'(1 << b));
      check("R8 irq enabled bit", 32'(irq[2]), 32'h1);
      rdchk("R6 status bit set", 8'h28, 32'h1 << b);
      wr(8'h2C, ~(32'h1 << b) & 32'h7F);
      check("R8 irq other enables", 32'(irq[2]), 32'h0);
    end
    wr(8'h28, 32'h7F);
    pulse(2, 7'h7F);
    wr(8'h28, 32'h7E);
    rdchk("R6 clear 6:1 keeps 0", 8'h28, 32'h01);
    wr(8'h28, 32'h00);
    rdchk("R6 zero write no effect", 8'h28, 32'h01);
    // R7 set beats clear
    pulse(2, 7'h08);
    addr = 8'h28; wdata = 32'h08; wr_en = 1'b1; ev[SW*2 +: SW] = 7'h08;
    @(negedge clk);
    wr_en = 1'b0; ev = '0;
    rdchk("R7 set wins", 8'h28, 32'h09);
    wr(8'h2C, 32'h7F);
    check("R8 irq pending", 32'(irq[2]), 32'h1);
    check("R8 irq only ch2", 32'(irq), 32'h4);
    wr(8'hF4, 32'h0);
    check("R8 line masked", 32'(irq), 32'h0);
    rdchk("R6 status kept under mask", 8'h28, 32'h09);

    // R4 channel reset on channel 5
    wr(8'h18, 32'd5);
    wr(8'hF4, 32'h20);
    wr(8'h2C, 32'h7F);
    pulse(5, 7'h10);
    check("R4 pre irq", 32'(irq[5]), 32'h1);
    wr(8'h1C, 32'h2);
    rdchk("R4 busy c1", 8'h1C, 32'h2);
    pulse(5, 7'h04);
    rdchk("R4 busy c3", 8'h1C, 32'h2);
    rdchk("R4 busy c4", 8'h1C, 32'h2);
    rdchk("R4 done c5", 8'h1C, 32'h0);
    rdchk("R4 status cleared", 8'h28, 32'h0);
    check("R4 irq cleared", 32'(irq[5]), 32'h0);
    check("R4 on cleared", 32'(on[5]), 32'h0);
    check("R4 base kept", base[DW*5 +: DW], base_exp(5));
    rdchk("R4 count kept", 8'h24, 32'd8);
    check("R4 neighbour on", 32'(on[4]), 32'h1);

    // R9 poll register
    wr(8'h18, 32'd3);
    wr(8'h14, 32'hFFFF_FFFF);
    rdchk("R9 poll fields", 8'h14, 32'h8000_0040);
    wr(8'h18, 32'd4);
    rdchk("R9 poll per channel", 8'h14, 32'h0);

    // R10 port banks
    for (int p = 0; p < NP; p++) begin
      wr(8'h40, 32'(p));
      wr(8'h44, 32'h1234_5678 * 32'(p + 1) ^ 32'(p * 32'h0F40));
    end
    for (int p = 0; p < NP; p++) begin
      wr(8'h40, 32'(p));
      rdchk("R10 port cfg", 8'h44, (32'h1234_5678 * 32'(p + 1) ^ 32'(p * 32'h0F40)) & 32'h0F7C);
    end
    wr(8'h40, 32'd4);
    wr(8'h44, 32'hFFFF_FFFF);
    rdchk("R10 bad port reads 0", 8'h44, 32'h0);
    wr(8'h40, 32'd0);
    rdchk("R10 bad port write ignored", 8'h44, 32'h1234_5678 & 32'h0F7C);

    // R5 engine reset
    wr(8'h10, 32'h1);
    rdchk("R5 busy", 8'h10, 32'h1);
    repeat (5) @(negedge clk);
    rdchk("R5 done", 8'h10, 32'h0);
    check("R5 all off", 32'(on), 32'h0);
    check("R5 base kept", base[DW*7 +: DW], base_exp(7));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule